// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator with Per-Parent Routing

This block gathers up to 128 level-sensitive interrupt lines, grouped into 32-bit words, and drives a small set of upstream interrupt outputs. Every source line passes through a two-stage synchronizer. The synchronized level is the status bit for that source. Software reads the status bits over a simple valid/ready register port. It gates each source with a per-word enable register.

Each upstream output has its own routing mask for every word. This lets one group of sources be split across several upstream lines. A source is pending for an output only when its status bit, its enable bit and that output's routing bit are all set. In low-power mode, a per-word wake mask is ORed into the enable. This lets chosen sources raise the outputs and the wake line even while their normal enable is off. Leaving low-power mode restores the plain enable.

Register layout, in bytes. Bits [9:8] select a region.
- Region 0 holds the word registers. Word `w` starts at `w*0x10`. Enable is at +0x0, status at +0x4 and the wake mask at +0x8.
- Region 1 holds the routing masks. The mask for output `p` and word `w` is at `0x100 + p*0x10 + w*0x4`.

Top module: `l2irq_agg`

## Requirements
- R1: After reset, every `irq_o` bit and `wake_o` are 0. Each word's enable reads back the `FWD_MASK` slice for that word, with word `w` in bits `[32w+31:32w]`. Every routing mask reads 0xFFFFFFFF, and every wake mask and status register reads 0.
- R2: `irq_o[p]` is 1 exactly when some word has a bit that is set in its status, in its effective enable and in routing mask `p` for that word.
- R3: `irq_o` follows a change of enable, routing mask, wake mask or `suspend_i` one clock edge after that change is registered. It follows a source line change three clock edges after the line is sampled: two synchronizer edges and one output edge.
- R4: The status register at word offset +0x4 returns the synchronized source levels, with source `32w+b` in bit `b`. Writes to it change no register and no output. No acknowledge is needed: a status bit falls only when its source falls.
- R5: Each output uses only its own routing masks. A source routed to output 1 but not to output 0 raises only `irq_o[1]`.
- R6: While `suspend_i` is 1 (with `WAKE_CAPABLE`=1), the effective enable of each word is its enable ORed with its wake mask. While `suspend_i` is 0, the effective enable is the enable alone.
- R7: `wake_o` is 1 only in the edge after a clock edge at which `suspend_i` was 1 and at least one output had a pending source.
- R8: Each accepted request (`req_ready_o` is always 1) gives exactly one `rsp_valid_o` pulse on the next edge. Reads of unmapped offsets return 0: word register select 3, regions 2 and 3, and words or outputs beyond the configured counts. Write responses carry data 0.
- R9: Enable, wake mask and routing registers hold written 32-bit values and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_WORDS*32 | Level-sensitive source lines, source 32w+b at bit 32w+b |
| suspend_i | input | 1 | Low-power mode; ORs the wake masks into the enables |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one edge after the request |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | NUM_PARENTS | Registered upstream interrupt levels |
| wake_o | output | 1 | Registered wake request |

## Verification
Register effects are due one edge after the write edge, so the bench samples `irq_o` on the falling edge after the write completes and again one edge later. The first sample must still show the old value and the second must show the new one. A source change needs three edges to reach `irq_o`. The bench drives sources on a falling edge and checks that the output is still low after two rising edges and high after the third. Read data is registered, so each read is sampled on the falling edge after the request's rising edge.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

    localparam int WORD_BITS = 32;

    typedef logic [WORD_BITS-1:0] word_t;

    // Select field of a word-region address, bits [3:2]
    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_WAKE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] REGION_WORD  = 2'd0;
    localparam logic [1:0] REGION_ROUTE = 2'd1;

endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.s1 = async_i;
        nxt_d.s2 = cur_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sync_o = cur_q.s2;

endmodule

// File: rtl/l2irq_regs.sv
module l2irq_regs
    import l2irq_pkg::*;
#(
    parameter int                      NUM_WORDS   = 4,
    parameter int                      NUM_PARENTS = 2,
    parameter int                      ADDR_W      = 10,
    parameter logic [NUM_WORDS*32-1:0] FWD_MASK    = '0
) (
    input  logic                                      clk_i,
    input  logic                                      rst_ni,
    input  logic                                      req_valid_i,
    input  logic                                      req_write_i,
    input  logic [ADDR_W-1:0]                         req_addr_i,
    input  word_t                                     req_wdata_i,
    input  logic [NUM_WORDS-1:0][31:0]                status_i,
    output logic                                      rsp_valid_o,
    output word_t                                     rsp_rdata_o,
    output logic [NUM_WORDS-1:0][31:0]                enable_o,
    output logic [NUM_WORDS-1:0][31:0]                wake_mask_o,
    output logic [NUM_PARENTS-1:0][NUM_WORDS-1:0][31:0] route_o
);

    localparam int REGION_W = ADDR_W - 8;

    typedef struct packed {
        logic [NUM_WORDS-1:0][31:0]                 en;
        logic [NUM_WORDS-1:0][31:0]                 wake;
        logic [NUM_PARENTS-1:0][NUM_WORDS-1:0][31:0] route;
        logic                                       rsp_valid;
        word_t                                      rsp_rdata;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [REGION_W-1:0] region;
    logic [1:0]          word_sel;
    reg_sel_e            reg_sel;
    logic [3:0]          route_p;
    logic [1:0]          route_w;
    logic                hit_word;
    logic                hit_route;
    logic                do_write;
    word_t               rd_data;

    always_comb begin
        nxt_d     = cur_q;
        rd_data   = '0;
        region    = req_addr_i[ADDR_W-1:8];
        word_sel  = req_addr_i[5:4];
        reg_sel   = reg_sel_e'(req_addr_i[3:2]);
        route_p   = req_addr_i[7:4];
        route_w   = req_addr_i[3:2];
        hit_word  = (region == REGION_W'(REGION_WORD));
        hit_route = (region == REGION_W'(REGION_ROUTE));
        do_write  = req_valid_i && req_write_i;

        for (int w = 0; w < NUM_WORDS; w++) begin
            if (hit_word && word_sel == 2'(w)) begin
                unique case (reg_sel)
                    SEL_ENABLE: begin
                        rd_data = cur_q.en[w];
                        if (do_write) nxt_d.en[w] = req_wdata_i;
                    end
                    SEL_STATUS: rd_data = status_i[w];
                    SEL_WAKE: begin
                        rd_data = cur_q.wake[w];
                        if (do_write) nxt_d.wake[w] = req_wdata_i;
                    end
                    default: rd_data = '0;
                endcase
            end
        end

        for (int p = 0; p < NUM_PARENTS; p++) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (hit_route && route_p == 4'(p) && route_w == 2'(w)) begin
                    rd_data = cur_q.route[p][w];
                    if (do_write) nxt_d.route[p][w] = req_wdata_i;
                end
            end
        end

        nxt_d.rsp_valid = req_valid_i;
        nxt_d.rsp_rdata = (req_valid_i && !req_write_i) ? rd_data : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.en        <= FWD_MASK;
            cur_q.wake      <= '0;
            cur_q.route     <= '1;
            cur_q.rsp_valid <= 1'b0;
            cur_q.rsp_rdata <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rsp_valid_o = cur_q.rsp_valid;
    assign rsp_rdata_o = cur_q.rsp_rdata;
    assign enable_o    = cur_q.en;
    assign wake_mask_o = cur_q.wake;
    assign route_o     = cur_q.route;

    AST_RSP_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o); // R8

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && hit_word && reg_sel == SEL_STATUS)
        |=> ($stable(enable_o) && $stable(wake_mask_o) && $stable(route_o))); // R4

endmodule

// File: rtl/l2irq_route.sv
module l2irq_route #(
    parameter int NUM_WORDS    = 4,
    parameter int NUM_PARENTS  = 2,
    parameter bit WAKE_CAPABLE = 1'b1
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic                                        suspend_i,
    input  logic [NUM_WORDS-1:0][31:0]                  status_i,
    input  logic [NUM_WORDS-1:0][31:0]                  enable_i,
    input  logic [NUM_WORDS-1:0][31:0]                  wake_mask_i,
    input  logic [NUM_PARENTS-1:0][NUM_WORDS-1:0][31:0] route_i,
    output logic [NUM_PARENTS-1:0]                      irq_o,
    output logic                                        wake_o
);

    typedef struct packed {
        logic [NUM_PARENTS-1:0] irq;
        logic                   wake;
    } out_t;

    out_t cur_q, nxt_d;

    logic [NUM_WORDS-1:0][31:0] wake_term;
    logic [NUM_WORDS-1:0][31:0] eff_en;

    generate
        if (WAKE_CAPABLE) begin : g_wake
            assign wake_term = suspend_i ? wake_mask_i : '0;
        end else begin : g_no_wake
            assign wake_term = '0;
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        for (int w = 0; w < NUM_WORDS; w++) begin
            eff_en[w] = enable_i[w] | wake_term[w];
        end
        for (int p = 0; p < NUM_PARENTS; p++) begin
            nxt_d.irq[p] = 1'b0;
            for (int w = 0; w < NUM_WORDS; w++) begin
                nxt_d.irq[p] = nxt_d.irq[p]
                             | (|(status_i[w] & eff_en[w] & route_i[p][w]));
            end
        end
        nxt_d.wake = suspend_i && (|nxt_d.irq);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign irq_o  = cur_q.irq;
    assign wake_o = cur_q.wake;

    AST_WAKE_NEEDS_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $past(suspend_i)); // R7

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> $past(|status_i)); // R2

endmodule

// File: rtl/l2irq_agg.sv
module l2irq_agg
    import l2irq_pkg::*;
#(
    parameter int                      NUM_WORDS    = 4,
    parameter int                      NUM_PARENTS  = 2,
    parameter int                      ADDR_W       = 10,
    parameter bit                      WAKE_CAPABLE = 1'b1,
    parameter logic [NUM_WORDS*32-1:0] FWD_MASK     = '0
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NUM_WORDS*32-1:0] src_i,
    input  logic                    suspend_i,
    input  logic                    req_valid_i,
    output logic                    req_ready_o,
    input  logic                    req_write_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic [31:0]             req_wdata_i,
    output logic                    rsp_valid_o,
    output logic [31:0]             rsp_rdata_o,
    output logic [NUM_PARENTS-1:0]  irq_o,
    output logic                    wake_o
);

    localparam int NUM_SRC = NUM_WORDS * WORD_BITS;

    logic [NUM_SRC-1:0]                         status_flat;
    logic [NUM_WORDS-1:0][31:0]                 status_w;
    logic [NUM_WORDS-1:0][31:0]                 enable_w;
    logic [NUM_WORDS-1:0][31:0]                 wake_w;
    logic [NUM_PARENTS-1:0][NUM_WORDS-1:0][31:0] route_w;

    assign req_ready_o = 1'b1;
    assign status_w    = status_flat;

    l2irq_sync #(
        .WIDTH (NUM_SRC)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (status_flat)
    );

    l2irq_regs #(
        .NUM_WORDS   (NUM_WORDS),
        .NUM_PARENTS (NUM_PARENTS),
        .ADDR_W      (ADDR_W),
        .FWD_MASK    (FWD_MASK)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .status_i    (status_w),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .enable_o    (enable_w),
        .wake_mask_o (wake_w),
        .route_o     (route_w)
    );

    l2irq_route #(
        .NUM_WORDS    (NUM_WORDS),
        .NUM_PARENTS  (NUM_PARENTS),
        .WAKE_CAPABLE (WAKE_CAPABLE)
    ) u_route (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .suspend_i   (suspend_i),
        .status_i    (status_w),
        .enable_i    (enable_w),
        .wake_mask_i (wake_w),
        .route_i     (route_w),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    AST_IDLE_AFTER_SUSPEND_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!suspend_i && !(|status_w)) |=> !wake_o); // R7

endmodule

// File: tb/l2irq_agg_bench.sv
module l2irq_agg_bench;

    localparam int NW = 4;
    localparam int NP = 2;
    localparam logic [NW*32-1:0] FWD = {32'h0, 32'h0, 32'h0, 32'h8000_0001};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NW*32-1:0] src = '0;
    logic            suspend = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [9:0]      req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NP-1:0]   irq;
    logic            wake;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    l2irq_agg #(
        .NUM_WORDS (NW),
        .NUM_PARENTS (NP),
        .ADDR_W (10),
        .WAKE_CAPABLE (1'b1),
        .FWD_MASK (FWD)
    ) u_l2irq_agg (
        .clk_i (clk), .rst_ni (rst_n), .src_i (src), .suspend_i (suspend),
        .req_valid_i (req_valid), .req_ready_o (req_ready), .req_write_i (req_write),
        .req_addr_i (req_addr), .req_wdata_i (req_wdata), .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata), .irq_o (irq), .wake_o (wake)
    );

    typedef struct packed {
        logic [1:0]  w;
        logic [31:0] s;
        logic [31:0] en;
        logic [31:0] r0;
        logic [31:0] r1;
        logic [1:0]  exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b11},
        '{2'd0, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00},
        '{2'd0, 32'h0000_0003, 32'h0000_0003, 32'h0000_0001, 32'h0000_0002, 2'b11},
        '{2'd0, 32'h0000_0002, 32'h0000_0003, 32'h0000_0001, 32'h0000_0002, 2'b10},
        '{2'd1, 32'h0000_0100, 32'h0000_0100, 32'h0000_0000, 32'h0000_0100, 2'b10},
        '{2'd3, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 2'b01},
        '{2'd2, 32'h0000_00F0, 32'h0000_000F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00}
    };

    function automatic logic [9:0] a_en(int w);     return 10'(w * 16);     endfunction
    function automatic logic [9:0] a_st(int w);     return 10'(w * 16 + 4); endfunction
    function automatic logic [9:0] a_wk(int w);     return 10'(w * 16 + 8); endfunction
    function automatic logic [9:0] a_rt(int p, int w); return 10'(256 + p * 16 + w * 4); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [9:0] addr, logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(logic [9:0] addr, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 rsp_valid", 32'(rsp_valid), 32'd1);
        data = rsp_rdata;
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        wait_neg(3);
        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 wake", 32'(wake), 32'd0);
        rst_n = 1'b1;
        wait_neg(1);
        bus_read(a_en(0), rd);  check("R1 enable word0", rd, 32'h8000_0001);
        bus_read(a_en(2), rd);  check("R1 enable word2", rd, 32'h0);
        bus_read(a_rt(1, 2), rd); check("R1 route", rd, 32'hFFFF_FFFF);
        bus_read(a_wk(1), rd);  check("R1 wake mask", rd, 32'h0);
        bus_read(a_st(0), rd);  check("R1 status", rd, 32'h0);

        // R2 R5 vector table
        foreach (VECS[i]) begin
            src = '0;
            bus_write(a_en(VECS[i].w), VECS[i].en);
            bus_write(a_rt(0, VECS[i].w), VECS[i].r0);
            bus_write(a_rt(1, VECS[i].w), VECS[i].r1);
            src[VECS[i].w*32 +: 32] = VECS[i].s;
            wait_neg(4);
            check($sformatf("R2 R5 vector %0d", i), 32'(irq), 32'(VECS[i].exp));
        end

        // R9 readback of written registers
        bus_read(a_rt(1, 1), rd); check("R9 route readback", rd, 32'h0000_0100);
        bus_write(a_wk(3), 32'h1234_5678);
        bus_read(a_wk(3), rd);  check("R9 wake readback", rd, 32'h1234_5678);
        bus_write(a_wk(3), 32'h0);

        // R3 source latency: three rising edges
        src = '0;
        bus_write(a_en(0), 32'h0000_0010);
        bus_write(a_rt(0, 0), 32'hFFFF_FFFF);
        bus_write(a_rt(1, 0), 32'hFFFF_FFFF);
        wait_neg(3);
        src[4] = 1'b1;
        wait_neg(2);
        check("R3 src after 2 edges", 32'(irq), 32'd0);
        wait_neg(1);
        check("R3 src after 3 edges", 32'(irq), 32'd3);
        // R3 register latency: one edge after write
        bus_write(a_en(0), 32'h0);
        check("R3 write edge", 32'(irq), 32'd3);
        wait_neg(1);
        check("R3 one edge later", 32'(irq), 32'd0);

        // R4 status readback and ignored writes
        src[32 +: 32] = 32'h0000_00A5;
        wait_neg(3);
        bus_read(a_st(1), rd);  check("R4 status", rd, 32'h0000_00A5);
        bus_write(a_st(1), 32'hFFFF_FFFF);
        bus_read(a_st(1), rd);  check("R4 status after write", rd, 32'h0000_00A5);
        bus_read(a_en(1), rd);  check("R4 enable untouched", rd, 32'h0000_0100);
        check("R4 irq untouched", 32'(irq), 32'd0);
        src[32 +: 32] = 32'h0;
        wait_neg(3);
        bus_read(a_st(1), rd);  check("R4 status drops with source", rd, 32'h0);

        // R8 unmapped offsets
        bus_read(10'h00C, rd);  check("R8 select 3", rd, 32'h0);
        bus_read(10'h204, rd);  check("R8 region 2", rd, 32'h0);
        bus_read(a_rt(5, 0), rd); check("R8 missing parent", rd, 32'h0);

        // R6 R7 suspend with wake mask; src[4] still high, enable word0 = 0
        bus_write(a_wk(0), 32'h0000_0010);
        wait_neg(2);
        check("R6 no suspend", 32'(irq), 32'd0);
        check("R7 no suspend", 32'(wake), 32'd0);
        suspend = 1'b1;
        wait_neg(1);
        check("R6 suspended irq", 32'(irq), 32'd3);
        check("R7 suspended wake", 32'(wake), 32'd1);
        suspend = 1'b0;
        wait_neg(1);
        check("R6 resume irq", 32'(irq), 32'd0);
        check("R7 resume wake", 32'(wake), 32'd0);
        src = '0;
        wait_neg(3);
        suspend = 1'b1;
        wait_neg(2);
        check("R7 suspended idle", 32'(wake), 32'd0);
        suspend = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule